// File: doc/BRIEF.md
# Two-Level Bounds Table Walker

This block resolves the bounds recorded for a pointer by walking a two-level table held in memory. A request supplies an optional base register with a displacement, an optional index register holding the pointer value to compare, the base of the first-level directory, a 32-bit or 64-bit mode select and a privilege bit. From these the block forms the directory entry address and reads that entry. If the entry is valid, it forms the address of a second-level entry and reads three words in this order: lower bound, upper bound and stored pointer.

The walk ends in one of three ways. If the stored pointer equals the requested pointer, the block returns the loaded bounds. If it does not, the block returns all-zero bounds. The all-zero upper bound means unrestricted access, because the upper bound is kept in one's complement. If the directory entry is not valid, the block raises a fault with a status word. Memory is reached through a request/response read port that has one read outstanding at a time. The pointer itself and the base address are never read.

Top module: `bound_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, and a request is taken only in that state. Request inputs that change while a walk is in progress do not alter that walk.
- R2: In 32-bit mode (`req_wide`=0) the directory entry address is base[31:12]·4 + cfg[31:12]·4096, taken modulo 2^32.
- R3: In 64-bit mode the directory entry address is F·8 + cfg[63:12]·4096, modulo 2^64. F is base[47+W:20], clipped at bit 63. W is 0 when `req_user`=0 and `user_ext` when `req_user`=1.
- R4: In 32-bit mode the table entry address E is base[11:2]·16 + dir[31:2]·4. The lower bound, upper bound and stored pointer are read in that order at E, E+4 and E+8, modulo 2^32.
- R5: In 64-bit mode E is base[19:3]·32 + dir[63:3]·8, and the three words are read in that order at E, E+8 and E+16.
- R6: When bit 0 of the directory entry is 0, exactly one read is made. `res_fault` pulses with `res_status` equal to the directory entry address ORed with 0x2.
- R7: When the stored pointer equals the requested pointer, `res_valid` pulses with `res_lb` and `res_ub` equal to the loaded words.
- R8: When the stored pointer differs from the requested pointer, `res_valid` pulses with `res_lb` and `res_ub` both zero.
- R9: When `req_has_base`=0 the base is zero and the displacement is not used. When `req_has_index`=0 the compared pointer is zero.
- R10: At most one read is outstanding. A request held without `mem_req_ready` keeps its address. Each result pulse lasts one cycle.
- R11: In 32-bit mode the upper 32 bits of every response word, base and index are ignored. The upper halves of the addresses, bounds and status are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| req_user | input | 1 | 1 = user privilege (use `user_ext`) |
| req_has_base | input | 1 | Base register present |
| req_base_reg | input | 64 | Base register value |
| req_disp | input | 64 | Displacement added to base |
| req_has_index | input | 1 | Index register present |
| req_index | input | 64 | Pointer value to compare |
| req_tbl_cfg | input | 64 | Directory base configuration |
| user_ext | input | 5 | User address-width extension W |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | One-cycle pulse: bounds returned |
| res_lb | output | 64 | Returned lower bound |
| res_ub | output | 64 | Returned upper bound (one's complement) |
| res_fault | output | 1 | One-cycle pulse: invalid directory entry |
| res_status | output | 64 | Fault status word |

## Verification
Two events can meet in one cycle: a result pulse and a waiting new request. The bench keeps `req_valid` high through every walk and loads it with changed base and index values. The request is therefore present in the same cycle as `res_valid` or `res_fault`. The result is judged correct when the walk's read addresses follow the original request and when `req_ready` stays low until after the pulse. A memory model with random acceptance and latency runs alongside, and a sweep covers every mode, privilege, operand-presence and outcome combination.

// File: rtl/bwalk_pkg.sv
// Shared constants and the walk state encoding for the bounds table walker.
// Assumes a 64-bit datapath; 32-bit mode uses the low half only.
package bwalk_pkg;
    localparam int XLEN    = 64;
    localparam int HALF    = XLEN / 2;
    localparam int DIR_LSB = 20;   // lowest base bit used for the directory index (64-bit)
    localparam int DIR_SPAN = 28;  // field width when the extension is zero
    localparam int DIR_MAX = XLEN - DIR_LSB; // widest field the base can supply

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_LO,
        ST_HI,
        ST_TAG,
        ST_DONE,
        ST_FAULT
    } walk_st_t;
endpackage

// File: rtl/bwalk_addr.sv
// Address former: builds the directory entry address and the address of the
// selected table entry field from the latched request and the directory entry.
// Purely combinational; assumes inputs stay stable while a read is pending.
module bwalk_addr
    import bwalk_pkg::*;
#(
    parameter int EXT_W = 5
) (
    input  logic             wide,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  cfg,
    input  logic [XLEN-1:0]  dir_ent,
    input  logic [EXT_W-1:0] ext,
    input  logic [1:0]       fld,
    output logic [XLEN-1:0]  dir_addr,
    output logic [XLEN-1:0]  fld_addr
);
    localparam int KW = $clog2(XLEN) + 1;

    logic [KW-1:0]   keep;
    logic [XLEN-1:0] hi_mask, hi_field, dir64, ent64;
    logic [HALF-1:0] dir32, ent32;

    // Directory address for both modes
    always_comb begin
        keep     = KW'(DIR_SPAN) + KW'(ext);
        hi_mask  = (keep >= KW'(DIR_MAX)) ? '1 : ((XLEN'(1) << keep) - XLEN'(1));
        hi_field = (base >> DIR_LSB) & hi_mask;
        dir64    = (hi_field << 3) + {cfg[XLEN-1:12], 12'b0};
        dir32    = ({12'b0, base[31:12]} << 2) + {cfg[31:12], 12'b0};
        dir_addr = wide ? dir64 : {{HALF{1'b0}}, dir32};
    end

    // Table entry field address for both modes
    always_comb begin
        ent64    = {42'b0, base[19:3], 5'b0} + {dir_ent[XLEN-1:3], 3'b0};
        ent32    = {18'b0, base[11:2], 4'b0} + {dir_ent[31:2], 2'b0};
        fld_addr = wide ? (ent64 + {59'b0, fld, 3'b0})
                        : {{HALF{1'b0}}, ent32 + {28'b0, fld, 2'b0}};
    end

    logic unused_bits;
    assign unused_bits = ^{cfg[11:0], dir_ent[1:0], base[1:0]};
endmodule

// File: rtl/bwalk_seq.sv
// Walk sequencer: latches a request, issues the four reads one at a time,
// checks the directory valid bit and the stored pointer, and pulses a result.
// Assumes a response never arrives in the cycle its request is accepted.
module bwalk_seq
    import bwalk_pkg::*;
#(
    parameter int EXT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wide,
    input  logic [XLEN-1:0]  req_base,
    input  logic [XLEN-1:0]  req_ptr,
    input  logic [XLEN-1:0]  req_cfg,
    input  logic [EXT_W-1:0] req_ext,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data,
    input  logic [XLEN-1:0]  dir_addr,
    input  logic [XLEN-1:0]  fld_addr,
    output logic             lat_wide,
    output logic [XLEN-1:0]  lat_base,
    output logic [XLEN-1:0]  lat_cfg,
    output logic [EXT_W-1:0] lat_ext,
    output logic [XLEN-1:0]  dir_ent,
    output logic [1:0]       fld_sel,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_lb,
    output logic [XLEN-1:0]  res_ub,
    output logic             res_fault,
    output logic [XLEN-1:0]  res_status
);
    walk_st_t        state;
    logic            pend;
    logic [XLEN-1:0] lat_ptr, lb_q, ub_q, stat_q, word;
    logic            reading;

    // Response word narrowed to the active mode
    always_comb begin
        word    = lat_wide ? mem_rsp_data : {{HALF{1'b0}}, mem_rsp_data[HALF-1:0]};
        reading = (state == ST_DIR) || (state == ST_LO) ||
                  (state == ST_HI)  || (state == ST_TAG);
    end

    // Read port and field select
    always_comb begin
        mem_req_valid = reading && !pend;
        mem_req_addr  = (state == ST_DIR) ? dir_addr : fld_addr;
        unique case (state)
            ST_HI:   fld_sel = 2'd1;
            ST_TAG:  fld_sel = 2'd2;
            default: fld_sel = 2'd0;
        endcase
    end

    // Result outputs, meaningful only during the pulse
    always_comb begin
        req_ready  = (state == ST_IDLE);
        res_valid  = (state == ST_DONE);
        res_fault  = (state == ST_FAULT);
        res_lb     = res_valid ? lb_q : '0;
        res_ub     = res_valid ? ub_q : '0;
        res_status = res_fault ? stat_q : '0;
    end

    // Walk state machine with request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= 1'b0;
            lat_wide <= 1'b0;
            lat_base <= '0;
            lat_cfg  <= '0;
            lat_ext  <= '0;
            lat_ptr  <= '0;
            dir_ent  <= '0;
            lb_q     <= '0;
            ub_q     <= '0;
            stat_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    lat_wide <= req_wide;
                    lat_base <= req_base;
                    lat_cfg  <= req_cfg;
                    lat_ext  <= req_ext;
                    lat_ptr  <= req_wide ? req_ptr : {{HALF{1'b0}}, req_ptr[HALF-1:0]};
                    pend     <= 1'b0;
                    state    <= ST_DIR;
                end
                ST_DIR, ST_LO, ST_HI, ST_TAG: begin
                    if (!pend) begin
                        if (mem_req_ready) pend <= 1'b1;
                    end else if (mem_rsp_valid) begin
                        pend <= 1'b0;
                        unique case (state)
                            ST_DIR: if (word[0]) begin
                                dir_ent <= word;
                                state   <= ST_LO;
                            end else begin
                                stat_q  <= dir_addr | XLEN'(2);
                                state   <= ST_FAULT;
                            end
                            ST_LO: begin lb_q <= word; state <= ST_HI; end
                            ST_HI: begin ub_q <= word; state <= ST_TAG; end
                            default: begin
                                if (word != lat_ptr) begin
                                    lb_q <= '0;
                                    ub_q <= '0;
                                end
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Guard: a stalled read keeps its request and address (R10)
    assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // Guard: result pulses last one cycle (R10)
    assert_pulse_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_fault) |=> !res_valid && !res_fault);
    // Guard: idle means no read and no result (R1)
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !res_valid && !res_fault);
    // Guard: fault status carries the marker bit (R6)
    assert_fault_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_status[1]);
    // Guard: mismatching pointer leads to zero bounds (R8)
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAG && pend && mem_rsp_valid && word != lat_ptr)
        |=> res_valid && res_lb == '0 && res_ub == '0);
    // Guard: narrow mode keeps upper halves clear (R11)
    assert_narrow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_valid || res_fault) && !lat_wide)
        |-> res_lb[XLEN-1:HALF] == '0 && res_ub[XLEN-1:HALF] == '0 &&
            res_status[XLEN-1:HALF] == '0);
endmodule

// File: rtl/bound_walker.sv
// Top of the two-level bounds table walker. Resolves the effective base and
// compared pointer from operand presence, picks the width extension by
// privilege, and joins the sequencer to the address former.
module bound_walker
    import bwalk_pkg::*;
#(
    parameter int EXT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wide,
    input  logic             req_user,
    input  logic             req_has_base,
    input  logic [XLEN-1:0]  req_base_reg,
    input  logic [XLEN-1:0]  req_disp,
    input  logic             req_has_index,
    input  logic [XLEN-1:0]  req_index,
    input  logic [XLEN-1:0]  req_tbl_cfg,
    input  logic [EXT_W-1:0] user_ext,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_lb,
    output logic [XLEN-1:0]  res_ub,
    output logic             res_fault,
    output logic [XLEN-1:0]  res_status
);
    logic [XLEN-1:0]  eff_base, eff_ptr;
    logic [EXT_W-1:0] eff_ext;
    logic             lat_wide;
    logic [XLEN-1:0]  lat_base, lat_cfg, dir_ent, dir_addr, fld_addr;
    logic [EXT_W-1:0] lat_ext;
    logic [1:0]       fld_sel;

    // Operand presence and privilege resolution
    always_comb begin
        eff_base = req_has_base  ? (req_base_reg + req_disp) : '0;
        eff_ptr  = req_has_index ? req_index : '0;
        eff_ext  = req_user ? user_ext : '0;
    end

    bwalk_seq #(.EXT_W(EXT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_wide     (req_wide),
        .req_base     (eff_base),
        .req_ptr      (eff_ptr),
        .req_cfg      (req_tbl_cfg),
        .req_ext      (eff_ext),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .dir_addr     (dir_addr),
        .fld_addr     (fld_addr),
        .lat_wide     (lat_wide),
        .lat_base     (lat_base),
        .lat_cfg      (lat_cfg),
        .lat_ext      (lat_ext),
        .dir_ent      (dir_ent),
        .fld_sel      (fld_sel),
        .res_valid    (res_valid),
        .res_lb       (res_lb),
        .res_ub       (res_ub),
        .res_fault    (res_fault),
        .res_status   (res_status)
    );

    bwalk_addr #(.EXT_W(EXT_W)) u_addr (
        .wide    (lat_wide),
        .base    (lat_base),
        .cfg     (lat_cfg),
        .dir_ent (dir_ent),
        .ext     (lat_ext),
        .fld     (fld_sel),
        .dir_addr(dir_addr),
        .fld_addr(fld_addr)
    );
endmodule

// File: tb/bound_walker_test.sv
`timescale 1ns/1ps
module bound_walker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_wide, req_user, req_has_base, req_has_index;
    logic [63:0] req_base_reg, req_disp, req_index, req_tbl_cfg;
    logic [4:0]  user_ext;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [63:0] mem_req_addr, mem_rsp_data;
    logic        res_valid, res_fault;
    logic [63:0] res_lb, res_ub, res_status;

    always #2.5 clk = ~clk;

    bound_walker uut (.*);

    int checks = 0;
    int fails  = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] seen [$];
    logic [31:0] mrng = 32'h1ACE_B00C;
    logic [31:0] srng = 32'h0BAD_F00D;

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    function automatic logic [63:0] rnd64();
        srng = step(srng); rnd64[63:32] = srng;
        srng = step(srng); rnd64[31:0]  = srng;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: random acceptance, latency 1..3 cycles, driven at negedge
    initial begin : memory_model
        int wait_cnt;
        logic [63:0] p_addr;
        wait_cnt = 0; p_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem.exists(p_addr) ? mem[p_addr] : (p_addr ^ 64'h5A5A_0F0F_3C3C_9696);
                end
            end
            mrng = step(mrng);
            mem_req_ready = mrng[3] | mrng[7];
            if (mem_req_valid && mem_req_ready && wait_cnt == 0 && !mem_rsp_valid) begin
                seen.push_back(mem_req_addr);
                p_addr   = mem_req_addr;
                wait_cnt = 1 + int'(mrng[9:8]) % 3;
            end
        end
    end

    // One lookup: kind 0 = invalid directory, 1 = pointer match, 2 = mismatch
    task automatic run_walk(input bit wide, input bit user, input logic [4:0] ext,
                            input bit hb, input logic [63:0] breg, input logic [63:0] disp,
                            input bit hi, input logic [63:0] idx, input logic [63:0] cfg,
                            input logic [63:0] tbl, input logic [63:0] lbv, input logic [63:0] ubv,
                            input int kind);
        logic [63:0] b, p, dir, ent, garb, btw, f, e_lb, e_ub, o_lb, o_ub, o_st;
        logic [63:0] want [4];
        int w, bits, nrd, tmo;
        bit busy_bad, o_v, o_f;
        string tdir, tfld, tres;
        b    = hb ? breg + disp : 64'd0;
        p    = hi ? idx : 64'd0;
        garb = wide ? 64'd0 : 64'hA5C3_9E17_0000_0000;
        if (!wide) p = p & 64'hFFFF_FFFF;
        btw  = wide ? ((tbl & ~64'h7) | ((kind == 0) ? 64'd0 : 64'd1))
                    : (garb | (tbl & 64'hFFFF_FFF8) | ((kind == 0) ? 64'd0 : 64'd1));
        w    = user ? int'(ext) : 0;
        bits = 28 + w;
        if (wide) begin
            f   = (bits >= 44) ? (b >> 20) : ((b >> 20) & ((64'd1 << bits) - 64'd1));
            dir = f * 8 + (cfg >> 12) * 4096;
            ent = ((b >> 3) & 64'h1FFFF) * 32 + (btw >> 3) * 8;
            for (int k = 0; k < 3; k++) want[k+1] = ent + 64'(k) * 8;
        end else begin
            dir = (((b & 64'hFFFF_FFFF) >> 12) * 4 + ((cfg & 64'hFFFF_FFFF) >> 12) * 4096) & 64'hFFFF_FFFF;
            ent = (((b >> 2) & 64'h3FF) * 16 + ((btw & 64'hFFFF_FFFF) >> 2) * 4) & 64'hFFFF_FFFF;
            for (int k = 0; k < 3; k++) want[k+1] = (ent + 64'(k) * 4) & 64'hFFFF_FFFF;
        end
        want[0] = dir;
        mem.delete(); seen.delete();
        mem[dir] = btw;
        if (kind != 0) begin
            mem[want[1]] = lbv;
            mem[want[2]] = ubv;
            mem[want[3]] = (kind == 1) ? (p | garb) : ((p ^ 64'h40) | garb);
        end
        e_lb = (kind == 1) ? (wide ? lbv : lbv & 64'hFFFF_FFFF) : 64'd0;
        e_ub = (kind == 1) ? (wide ? ubv : ubv & 64'hFFFF_FFFF) : 64'd0;
        nrd  = (kind == 0) ? 1 : 4;
        tdir = !hb ? "R9 dir" : (wide ? "R3 dir" : "R2 dir");
        tfld = wide ? "R5 field" : "R4 field";
        tres = !wide ? "R11 bounds" : (!hi && kind == 1) ? "R9 bounds" : (kind == 1) ? "R7 bounds" : "R8 bounds";

        @(negedge clk);
        req_wide = wide; req_user = user; user_ext = ext;
        req_has_base = hb; req_base_reg = breg; req_disp = disp;
        req_has_index = hi; req_index = idx; req_tbl_cfg = cfg;
        req_valid = 1'b1;
        tmo = 0;
        while (!req_ready && tmo < 100) begin @(negedge clk); tmo++; end
        @(negedge clk);
        // Decoy request held during the walk and at the result cycle
        req_base_reg = ~breg; req_index = idx ^ 64'hFF; req_tbl_cfg = cfg ^ 64'h7000;
        tmo = 0; busy_bad = 0;
        while (!(res_valid || res_fault) && tmo < 2000) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk); tmo++;
        end
        if (tmo >= 2000) chk(0, "R10 watchdog", 64'(tmo), 64'd2000);
        o_v = res_valid; o_f = res_fault; o_lb = res_lb; o_ub = res_ub; o_st = res_status;
        @(negedge clk);
        chk(!res_valid && !res_fault, "R10 pulse width", {63'd0, res_valid | res_fault}, 64'd0);
        req_valid = 1'b0;
        @(negedge clk);

        chk(!busy_bad, "R1 busy ready", {63'd0, busy_bad}, 64'd0);
        if (kind == 0) begin
            chk(o_f && !o_v, "R6 fault kind", {62'd0, o_f, o_v}, 64'd2);
            chk(o_st == (dir | 64'd2), wide ? "R6 status" : "R11 status", o_st, dir | 64'd2);
        end else begin
            chk(o_v && !o_f, (kind == 1) ? "R7 kind" : "R8 kind", {62'd0, o_f, o_v}, 64'd1);
            chk(o_lb == e_lb, tres, o_lb, e_lb);
            chk(o_ub == e_ub, tres, o_ub, e_ub);
        end
        chk(seen.size() == nrd, "R6 read count", 64'(seen.size()), 64'(nrd));
        for (int k = 0; k < nrd && k < seen.size(); k++)
            chk(seen[k] == want[k], (k == 0) ? tdir : tfld, seen[k], want[k]);
    endtask

    initial begin : stimulus
        rst_n = 1'b0; req_valid = 1'b0; req_wide = 1'b0; req_user = 1'b0;
        req_has_base = 1'b0; req_has_index = 1'b0; req_base_reg = '0; req_disp = '0;
        req_index = '0; req_tbl_cfg = '0; user_ext = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !res_valid && !res_fault, "R1 reset state",
            {60'd0, req_ready, mem_req_valid, res_valid, res_fault}, 64'h8);

        // Sweep of mode, privilege, operand presence and outcome
        for (int wd = 0; wd < 2; wd++)
            for (int us = 0; us < 2; us++)
                for (int hb = 0; hb < 2; hb++)
                    for (int hx = 0; hx < 2; hx++)
                        for (int kd = 0; kd < 3; kd++)
                            run_walk(wd[0], us[0], 5'(rnd64()), hb[0], rnd64(), rnd64(), hx[0],
                                     rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), kd);

        // Corner: 32-bit address wrap at the top of the space (R11)
        run_walk(1'b0, 1'b0, 5'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'hC, 1'b1, 64'h1234_0000_89AB_CDEF,
                 64'h0000_0000_FFFF_F000, 64'h0000_0000_FFFF_FFF8, 64'h1111_2222_3333_4444,
                 64'h5555_6666_7777_8888, 1);
        // Corner: widest user extension keeps every upper base bit (R3)
        run_walk(1'b1, 1'b1, 5'd31, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 64'h42,
                 64'd0, 64'h0000_7000_0000_0000, 64'h10, 64'h20, 1);
        // Corner: supervisor ignores the configured extension (R3)
        run_walk(1'b1, 1'b0, 5'd31, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 64'h42,
                 64'd0, 64'h0000_7000_0000_0000, 64'h10, 64'h20, 2);
        // Corner: extension of 16 just reaches bit 63 (R3)
        run_walk(1'b1, 1'b1, 5'd16, 1'b1, 64'h8000_0000_0010_0000, 64'd0, 1'b0, 64'd0,
                 64'h0000_1234_5678_9000, 64'h0000_0FFF_0000_0008, 64'hAA, 64'hBB, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Global watchdog
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R10 global watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule